// File: doc/BRIEF.md
# Nibble-Field Priority Interrupt Controller

This block arbitrates 28 interrupt sources. Each source owns a 4-bit field inside one of four 32-bit control words. The low three bits of a field hold the source's priority level, and level zero masks the source. The top bit of a field is a per-field write strobe. A field changes only when that bit is set in the written data. For an edge source, the same bit also clears the latched edge. Software can therefore change one priority, mask a source, or acknowledge a pending edge in a single write, without disturbing the other seven fields of the word.

Six of the sources are external pins. Each pin passes through a two-flop synchroniser and an edge detector whose active edge comes from a polarity word. A detected edge sets a pending latch that stays set until it is acknowledged. The other 22 sources are level-sensitive and follow their inputs. Every cycle the block reports the highest priority level among the active, unmasked sources, together with the index of the source that wins. Both outputs are registered.

Source index order is: external 1-4 (0-3), timers 1-4 (4-7), two UARTs (8-9), two parallel-port sources (10-11), USB 0-7 (12-19), DMA (20), Ethernet receive, transmit and control (21-23), QSPI (24), external 5 (25), external 6 (26), watchdog timeout (27).

Top module: `nibble_irq_ctrl`

## Requirements
- R1: After reset, all priorities and pending latches are zero. The polarity word reads 0xF0000060, which selects rising edges for every external source. Both outputs are zero.
- R2: Addresses 0-3 select the control words. Source s lives in word s/8, in field bits [31-4*(s%8) -: 4]. Address 4 selects the polarity word. Every other address reads 0 and ignores writes.
- R3: A field written with bit 3 set loads bits 2:0 as its priority. A field written with bit 3 clear keeps its priority and its pending latch.
- R4: A source whose priority is 0 never wins arbitration.
- R5: Level sources are every source except 0-3, 25 and 26. A level source is active while its input is high. Bit 3 of its field reads the input. Its effect on the outputs appears one clock edge after the input changes.
- R6: Sources 0-3, 25 and 26 are edge sources. Each is synchronised by two flops, and the selected edge sets a pending latch that reads in bit 3. The outputs reflect the new pending state four clock edges after the pin changes.
- R7: A write with bit 3 set in an edge source's field clears its pending latch. This covers both acknowledge and mask. An edge detected in the same cycle as that write leaves the latch set.
- R8: Polarity bit 31-s controls edge source s, where 1 selects rising and 0 selects falling. The bits for non-edge sources read 0.
- R9: irq_level is the highest priority among the active sources with non-zero priority, and irq_id is the index of the winner. On a tie, the lowest index wins. When no source qualifies, both outputs read 0. The outputs are registered one edge after the state they reflect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register select, used for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_in | input | 28 | Raw interrupt source inputs, indexed by source number |
| irq_level | output | 3 | Highest active priority level, 0 when none |
| irq_id | output | 5 | Index of the winning source |

## Verification
Read data is combinational, so the bench samples it one step after it drives reg_addr. A level input shows at the outputs after one rising edge. An external pin needs three edges to set its latch and a fourth to reach the outputs. In the table-driven loop, each vector is given six edges to settle, so that every result has landed before it is sampled. The directed tests sample at falling edges on the exact cycle each result is due. They also sample on the cycle before, to confirm the result is not early. One further test places an acknowledge write on the same cycle as a fresh edge.

// File: rtl/nfic_pkg.sv
package nfic_pkg;
    localparam int NUM_SRC        = 28;
    localparam int PRIO_W         = 3;
    localparam int FIELD_W        = 4;
    localparam int FIELDS_PER_REG = 8;
    localparam int NUM_CTRL       = 4;
    localparam int DATA_W         = 32;
    localparam int ADDR_W         = 3;
    localparam int ID_W           = $clog2(NUM_SRC);
    localparam int POL_ADDR       = NUM_CTRL;

    // Sources 0-3 and 25-26 are edge-captured pins.
    localparam logic [NUM_SRC-1:0] EDGE_SRC = 28'h600000F;

    // Low bit of the field belonging to source s (first source at the top).
    function automatic int fld_lsb(int s);
        return DATA_W - FIELD_W * ((s % FIELDS_PER_REG) + 1);
    endfunction

    // Polarity bit belonging to source s.
    function automatic int pol_bit(int s);
        return DATA_W - 1 - s;
    endfunction
endpackage

// File: rtl/nfic_edge_sync.sv
module nfic_edge_sync
    import nfic_pkg::*;
#(
    parameter int                 N_SRC = NUM_SRC,
    parameter logic [N_SRC-1:0]   EDGES = EDGE_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_in,
    input  logic [N_SRC-1:0] rise_sel,
    output logic [N_SRC-1:0] edge_hit
);
    typedef struct packed {
        logic [N_SRC-1:0] meta;
        logic [N_SRC-1:0] sync;
        logic [N_SRC-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = src_in & EDGES;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_det
        if (EDGES[g]) begin : g_pin
            assign edge_hit[g] = rise_sel[g] ? ( st_q.sync[g] & ~st_q.prev[g])
                                             : (~st_q.sync[g] &  st_q.prev[g]);
        end else begin : g_none
            assign edge_hit[g] = 1'b0;
        end
    end
endmodule

// File: rtl/nfic_regs.sv
module nfic_regs
    import nfic_pkg::*;
#(
    parameter int               N_SRC = NUM_SRC,
    parameter int               P_W   = PRIO_W,
    parameter logic [N_SRC-1:0] EDGES = EDGE_SRC
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [N_SRC-1:0]             src_in,
    input  logic [N_SRC-1:0]             edge_hit,
    output logic [DATA_W-1:0]            rdata,
    output logic [N_SRC-1:0][P_W-1:0]    prio,
    output logic [N_SRC-1:0]             active,
    output logic [N_SRC-1:0]             rise_sel
);
    function automatic logic [DATA_W-1:0] build_pol_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int s = 0; s < N_SRC; s++)
            if (EDGES[s]) m[pol_bit(s)] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] POL_MASK = build_pol_mask();

    typedef struct packed {
        logic [N_SRC-1:0][P_W-1:0] prio;
        logic [N_SRC-1:0]          pend;
        logic [DATA_W-1:0]         pol;
    } regs_t;

    regs_t            st_d, st_q;
    logic [N_SRC-1:0] fld_wr;

    // Per-field write strobe: word matches and the field's top bit is set.
    always_comb begin
        for (int s = 0; s < N_SRC; s++)
            fld_wr[s] = wr_en && (int'(addr) == s / FIELDS_PER_REG)
                        && wdata[fld_lsb(s) + P_W];
    end

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < N_SRC; s++) begin
            if (fld_wr[s]) st_d.prio[s] = wdata[fld_lsb(s) +: P_W];
            if (EDGES[s]) st_d.pend[s] = edge_hit[s] | (st_q.pend[s] & ~fld_wr[s]);
            else          st_d.pend[s] = 1'b0;
        end
        if (wr_en && int'(addr) == POL_ADDR) st_d.pol = wdata & POL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prio <= '0;
            st_q.pend <= '0;
            st_q.pol  <= POL_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int s = 0; s < N_SRC; s++) begin
            prio[s]     = st_q.prio[s];
            active[s]   = EDGES[s] ? st_q.pend[s] : src_in[s];
            rise_sel[s] = st_q.pol[pol_bit(s)];
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(addr) < NUM_CTRL) begin
            for (int s = 0; s < N_SRC; s++) begin
                if (int'(addr) == s / FIELDS_PER_REG) begin
                    rdata[fld_lsb(s) +: P_W] = st_q.prio[s];
                    rdata[fld_lsb(s) + P_W]  = EDGES[s] ? st_q.pend[s] : src_in[s];
                end
            end
        end else if (int'(addr) == POL_ADDR) begin
            rdata = st_q.pol;
        end
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_chk
        localparam int LSB  = fld_lsb(g);
        localparam int WIDX = g / FIELDS_PER_REG;

        // R3: no strobe for this field means the priority holds
        a_r3_prio_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && int'(addr) == WIDX && wdata[LSB + P_W]) |=> $stable(st_q.prio[g]));

        if (EDGES[g]) begin : g_edge
            // R7: acknowledge without a coincident edge clears the latch
            a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && int'(addr) == WIDX && wdata[LSB + P_W] && !edge_hit[g])
                |=> !st_q.pend[g]);
            // R7: a detected edge always leaves the latch set
            a_r7_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
                edge_hit[g] |=> st_q.pend[g]);
        end
    end
endmodule

// File: rtl/nfic_arbiter.sv
module nfic_arbiter
    import nfic_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int P_W   = PRIO_W,
    parameter int I_W   = ID_W
) (
    input  logic [N_SRC-1:0][P_W-1:0] prio,
    input  logic [N_SRC-1:0]          active,
    output logic [P_W-1:0]            best_lvl,
    output logic [I_W-1:0]            best_id
);
    // Strictly-greater scan from index 0 keeps the lowest index on ties.
    always_comb begin
        best_lvl = '0;
        best_id  = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (active[s] && prio[s] > best_lvl) begin
                best_lvl = prio[s];
                best_id  = I_W'(s);
            end
        end
    end
endmodule

// File: rtl/nibble_irq_ctrl.sv
module nibble_irq_ctrl
    import nfic_pkg::*;
#(
    parameter int               N_SRC = NUM_SRC,
    parameter int               P_W   = PRIO_W,
    parameter int               I_W   = ID_W,
    parameter logic [N_SRC-1:0] EDGES = EDGE_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [N_SRC-1:0]   src_in,
    output logic [P_W-1:0]     irq_level,
    output logic [I_W-1:0]     irq_id
);
    typedef struct packed {
        logic [P_W-1:0] lvl;
        logic [I_W-1:0] id;
    } out_t;

    logic [N_SRC-1:0]          edge_hit;
    logic [N_SRC-1:0]          rise_sel;
    logic [N_SRC-1:0]          active;
    logic [N_SRC-1:0][P_W-1:0] prio;
    logic [P_W-1:0]            best_lvl;
    logic [I_W-1:0]            best_id;
    out_t                      out_d, out_q;

    nfic_edge_sync #(.N_SRC(N_SRC), .EDGES(EDGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .rise_sel (rise_sel),
        .edge_hit (edge_hit)
    );

    nfic_regs #(.N_SRC(N_SRC), .P_W(P_W), .EDGES(EDGES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .src_in   (src_in),
        .edge_hit (edge_hit),
        .rdata    (reg_rdata),
        .prio     (prio),
        .active   (active),
        .rise_sel (rise_sel)
    );

    nfic_arbiter #(.N_SRC(N_SRC), .P_W(P_W), .I_W(I_W)) u_arb (
        .prio     (prio),
        .active   (active),
        .best_lvl (best_lvl),
        .best_id  (best_id)
    );

    always_comb begin
        out_d     = out_q;
        out_d.lvl = best_lvl;
        out_d.id  = best_id;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_level = out_q.lvl;
    assign irq_id    = out_q.id;

    for (genvar g = 0; g < N_SRC; g++) begin : g_out_chk
        // R9: an active unmasked source is never beaten by a lower level or a
        // higher index at the same level
        a_r9_max_low_index: assert property (@(posedge clk) disable iff (!rst_n)
            (active[g] && prio[g] != '0) |=>
                (irq_level > $past(prio[g])) ||
                (irq_level == $past(prio[g]) && irq_id <= I_W'(g)));
        // R4: a masked source never wins
        a_r4_masked_loses: assert property (@(posedge clk) disable iff (!rst_n)
            (prio[g] == '0) |=> !(irq_level != '0 && irq_id == I_W'(g)));
    end
endmodule

// File: tb/nibble_irq_ctrl_tb.sv
module nibble_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [27:0] src_in = '0;
    logic [2:0]  irq_level;
    logic [4:0]  irq_id;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nibble_irq_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_in    (src_in),
        .irq_level (irq_level),
        .irq_id    (irq_id)
    );

    localparam logic [27:0] S0  = 28'h0000001;
    localparam logic [27:0] S1  = 28'h0000002;
    localparam logic [27:0] S2  = 28'h0000004;
    localparam logic [27:0] S4  = 28'h0000010;
    localparam logic [27:0] S12 = 28'h0001000;
    localparam logic [27:0] S25 = 28'h2000000;

    typedef struct packed {
        logic [3:0]  req;
        logic        we;
        logic [2:0]  waddr;
        logic [31:0] wdata;
        logic [27:0] src;
        logic [2:0]  lvl;
        logic [4:0]  id;
        logic [2:0]  raddr;
        logic [31:0] rdata;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'd3, 1'b1, 3'd0, 32'h88888888, 28'h0,     3'd0, 5'd0,  3'd0, 32'h00000000}, // R3 mask all
        '{4'd5, 1'b0, 3'd0, 32'h0,        S4,        3'd0, 5'd0,  3'd0, 32'h00008000}, // R5 R4 masked level
        '{4'd3, 1'b1, 3'd0, 32'h0000B000, S4,        3'd3, 5'd4,  3'd0, 32'h0000B000}, // R3 set level 3
        '{4'd9, 1'b1, 3'd1, 32'h0000D000, S4 | S12,  3'd5, 5'd12, 3'd1, 32'h0000D000}, // R9 higher wins
        '{4'd9, 1'b1, 3'd0, 32'h0000D000, S4 | S12,  3'd5, 5'd4,  3'd0, 32'h0000D000}, // R9 tie low index
        '{4'd4, 1'b1, 3'd0, 32'h00008000, S4 | S12,  3'd5, 5'd12, 3'd0, 32'h00008000}, // R4 mask loses
        '{4'd6, 1'b1, 3'd0, 32'hF0000000, S0 | S12,  3'd7, 5'd0,  3'd0, 32'hF0000000}, // R6 rising edge
        '{4'd6, 1'b0, 3'd0, 32'h0,        S12,       3'd7, 5'd0,  3'd0, 32'hF0000000}, // R6 latch holds
        '{4'd7, 1'b1, 3'd0, 32'hF0000000, S12,       3'd5, 5'd12, 3'd0, 32'h70000000}, // R7 ack keeps prio
        '{4'd3, 1'b1, 3'd0, 32'h30000000, S12,       3'd5, 5'd12, 3'd0, 32'h70000000}, // R3 strobe clear
        '{4'd8, 1'b1, 3'd4, 32'h00000000, S12,       3'd5, 5'd12, 3'd4, 32'h00000000}, // R8 all falling
        '{4'd8, 1'b1, 3'd3, 32'h0E000000, S12 | S25, 3'd5, 5'd12, 3'd3, 32'h06000000}, // R8 rise ignored
        '{4'd8, 1'b0, 3'd0, 32'h0,        S12,       3'd6, 5'd25, 3'd3, 32'h0E000000}, // R8 fall latched
        '{4'd7, 1'b1, 3'd3, 32'h08000000, S12,       3'd5, 5'd12, 3'd3, 32'h00000000}, // R7 mask clears
        '{4'd8, 1'b1, 3'd4, 32'hFFFFFFFF, S12,       3'd5, 5'd12, 3'd4, 32'hF0000060}, // R8 unused bits
        '{4'd9, 1'b0, 3'd0, 32'h0,        28'h0,     3'd0, 5'd0,  3'd1, 32'h00005000}  // R9 none active
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, "read", reg_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "irq_level", 32'(irq_level), 32'd0);
        chk("R1", "irq_id", 32'(irq_id), 32'd0);
        for (int a = 0; a < 4; a++) read_chk("R1", 3'(a), 32'h0);
        read_chk("R1", 3'd4, 32'hF0000060);

        // Table walk: each vector is given six edges to settle
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            src_in = VECS[v].src;
            if (VECS[v].we) begin
                reg_we = 1'b1; reg_addr = VECS[v].waddr; reg_wdata = VECS[v].wdata;
            end
            @(negedge clk);
            reg_we = 1'b0;
            repeat (5) @(negedge clk);
            chk($sformatf("R%0d vec%0d", VECS[v].req, v), "irq_level", 32'(irq_level), 32'(VECS[v].lvl));
            chk($sformatf("R%0d vec%0d", VECS[v].req, v), "irq_id", 32'(irq_id), 32'(VECS[v].id));
            read_chk($sformatf("R%0d vec%0d", VECS[v].req, v), VECS[v].raddr, VECS[v].rdata);
        end

        // R2 unmapped address: reads 0, write has no effect
        reg_write(3'd5, 32'hFFFFFFFF);
        read_chk("R2", 3'd5, 32'h0);
        read_chk("R2", 3'd0, 32'h70000000);
        read_chk("R2", 3'd4, 32'hF0000060);

        // R7 edge on source 1 lands in the same cycle as its acknowledge write
        @(negedge clk);
        src_in = S1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0A000000;
        @(negedge clk);
        reg_we = 1'b0;
        repeat (2) @(negedge clk);
        read_chk("R7", 3'd0, 32'h7A000000);
        chk("R7", "irq_level", 32'(irq_level), 32'd2);
        chk("R7", "irq_id", 32'(irq_id), 32'd1);

        // R5 level input reaches the outputs after exactly one edge
        @(negedge clk);
        src_in = S1 | S12;
        #1;
        chk("R5", "irq_level before edge", 32'(irq_level), 32'd2);
        @(negedge clk);
        chk("R5", "irq_level after edge", 32'(irq_level), 32'd5);
        chk("R5", "irq_id after edge", 32'(irq_id), 32'd12);

        // R6 edge pin reaches the outputs on the fourth edge
        reg_write(3'd0, 32'h0A000000);   // acknowledge source 1
        src_in = '0;
        reg_write(3'd0, 32'h00C00000);   // source 2 priority 4
        repeat (2) @(negedge clk);
        chk("R6", "irq_level idle", 32'(irq_level), 32'd0);
        src_in = S2;
        repeat (3) @(negedge clk);
        chk("R6", "irq_level third edge", 32'(irq_level), 32'd0);
        @(negedge clk);
        chk("R6", "irq_level fourth edge", 32'(irq_level), 32'd4);
        chk("R6", "irq_id fourth edge", 32'(irq_id), 32'd2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule